// File: doc/BRIEF.md
# Host Command Mailbox

This block is the register face of a command channel between a host processor and a management microcontroller. The host sees a small address window on a plain 32-bit register bus. It stages up to 16 bytes of arguments in a write buffer, then writes a command word. That write latches the opcode, the sub-command and the size. It also sets a busy flag and sends a one-cycle doorbell to the controller.

The controller reads the latched fields and the staged argument words. It may fill a 16-byte read buffer with results over a valid/ready port. It finishes by pulsing a done strobe, together with an error flag and an 8-bit error code. If the command asked for a completion interrupt, completion sets a pending flag and raises the host interrupt. The host acknowledges the interrupt by writing a one to the pending bit of the status word.

The fill port follows valid/ready rules. The block raises `ctl_fill_ready` only while a command is outstanding. A word transfers on a cycle where valid and ready are both high. A producer holding valid while ready is low waits, and nothing is written. The controller's done strobe and error inputs are plain single-cycle control pins with no handshake.

Top module: `ctl_mailbox`

## Requirements
- R1: After reset, busy, error, pending, overrun, doorbell and the host interrupt are all low. A status read returns only the initiator identity in bits [23:16].
- R2: When a host write to offset 0x00 arrives while idle, the block latches opcode from bits [7:0], interrupt request from bit 8, sub-command from bits [15:12] and size from bits [23:16]. It then raises `ctl_doorbell` for exactly one cycle, in the cycle after the write.
- R3: Status bit 0 (busy) is set from the accepted command write until the controller's done strobe. The latched command fields stay unchanged for that whole span.
- R4: A done strobe clears busy and loads status bit 1 from `ctl_err` and bits [31:24] from `ctl_err_code`. Accepting a new command clears both.
- R5: Completion of a command whose bit 8 was set sets status bit 2 (pending). Completion of a command without it leaves pending unchanged. `host_irq` is pending ANDed with bit 8 of the most recently accepted command.
- R6: A host write to offset 0x04 with bit 2 set clears pending. All other bits of that write are ignored.
- R7: A command write while busy changes nothing in the latched command and sets `ctl_overrun`, which stays high until reset.
- R8: Status bits [15:12] echo the latched sub-command, and bits [23:16] carry the INITIATOR_ID parameter.
- R9: A host word write at 0x80+4k stores word k, which the controller reads by index. Host reads of 0x00 and of the write buffer return zero.
- R10: Words accepted on the fill port at index k are read by the host at 0x90+4k. With `host_byte_rd` high, the host reads byte `host_addr[1:0]` of that word, zero-extended. Fill transfers are refused while idle.
- R11: A done strobe while idle has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 8 | Host byte address |
| host_wr_en | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_byte_rd | input | 1 | Select byte read of the read buffer |
| host_rdata | output | 32 | Host read data (combinational) |
| host_irq | output | 1 | Completion interrupt to host |
| ctl_doorbell | output | 1 | One-cycle new-command pulse |
| ctl_opcode | output | 8 | Latched opcode |
| ctl_subcmd | output | 4 | Latched sub-command |
| ctl_size | output | 8 | Latched data size |
| ctl_wbuf_idx | input | 2 | Write buffer word index |
| ctl_wbuf_word | output | 32 | Write buffer word at index |
| ctl_fill_valid | input | 1 | Fill word valid |
| ctl_fill_ready | output | 1 | Fill port ready (busy) |
| ctl_fill_idx | input | 2 | Fill word index |
| ctl_fill_data | input | 32 | Fill word |
| ctl_done | input | 1 | Command completion strobe |
| ctl_err | input | 1 | Completion failed |
| ctl_err_code | input | 8 | Completion error code |
| ctl_overrun | output | 1 | Sticky rejected-command flag |

## Verification
The assertions check several rules on every cycle. The doorbell is a single pulse. Busy rises only together with a doorbell and holds until done. The latched opcode does not move while a command is outstanding. The host interrupt never appears without a pending flag. Overrun never falls once set.

Other behaviour only the bench's scenarios can show. These are the register-level values: error and code loading and clearing, the write-one-to-clear masking of the other status bits, and the byte lanes of the read buffer. The same goes for the fill port refusing data while idle. The irq enable following the newest command while a stale pending flag stays set also needs a scenario.

// File: rtl/ctl_mailbox_pkg.sv
package ctl_mailbox_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int BUF_BYTES = 16;
  localparam int BUF_WORDS = BUF_BYTES / (DATA_W / 8);
  localparam int IDX_W    = $clog2(BUF_WORDS);

  localparam logic [ADDR_W-1:0] OFF_CMD  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h04;
  localparam logic [3:0]        PAGE_WBUF = 4'h8;
  localparam logic [3:0]        PAGE_RBUF = 4'h9;

  localparam int STAT_BUSY = 0;
  localparam int STAT_ERR  = 1;
  localparam int STAT_PEND = 2;

  typedef struct packed {
    logic [7:0] size;
    logic [3:0] sub;
    logic       ioc;
    logic [7:0] op;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [DATA_W-1:0] w);
    cmd_t c;
    c.op   = w[7:0];
    c.ioc  = w[8];
    c.sub  = w[15:12];
    c.size = w[23:16];
    return c;
  endfunction
endpackage

// File: rtl/mbx_wordbuf.sv
module mbx_wordbuf #(
  parameter int WORDS = 4,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        words[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))
        words[g] <= wr_data;
    end
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import ctl_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              pend_clr,
  input  logic              done,
  input  logic              done_err,
  input  logic [7:0]        done_code,
  output logic              busy,
  output logic              err,
  output logic [7:0]        err_code,
  output logic              pend,
  output logic              ioc_en,
  output cmd_t              cmd,
  output logic              doorbell,
  output logic              overrun
);
  logic accept, finish;
  assign accept = cmd_wr && !busy;
  assign finish = done && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err      <= 1'b0;
      err_code <= '0;
      pend     <= 1'b0;
      ioc_en   <= 1'b0;
      cmd      <= '0;
      doorbell <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      doorbell <= accept;
      if (accept) begin
        cmd      <= unpack_cmd(cmd_data);
        ioc_en   <= cmd_data[8];
        busy     <= 1'b1;
        err      <= 1'b0;
        err_code <= '0;
      end
      if (cmd_wr && busy)
        overrun <= 1'b1;
      if (finish) begin
        busy     <= 1'b0;
        err      <= done_err;
        err_code <= done_code;
      end
      if (pend_clr)
        pend <= 1'b0;
      if (finish && ioc_en)
        pend <= 1'b1;
    end
  end
endmodule

// File: rtl/ctl_mailbox.sv
module ctl_mailbox
  import ctl_mailbox_pkg::*;
#(
  parameter logic [7:0] INITIATOR_ID = 8'h2C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  host_addr,
  input  logic        host_wr_en,
  input  logic [31:0] host_wdata,
  input  logic        host_byte_rd,
  output logic [31:0] host_rdata,
  output logic        host_irq,
  output logic        ctl_doorbell,
  output logic [7:0]  ctl_opcode,
  output logic [3:0]  ctl_subcmd,
  output logic [7:0]  ctl_size,
  input  logic [1:0]  ctl_wbuf_idx,
  output logic [31:0] ctl_wbuf_word,
  input  logic        ctl_fill_valid,
  output logic        ctl_fill_ready,
  input  logic [1:0]  ctl_fill_idx,
  input  logic [31:0] ctl_fill_data,
  input  logic        ctl_done,
  input  logic        ctl_err,
  input  logic [7:0]  ctl_err_code,
  output logic        ctl_overrun
);
  logic             busy, err, pend, ioc_en;
  logic [7:0]       err_code;
  cmd_t             cmd;
  logic             hit_cmd, hit_stat, hit_wbuf, hit_rbuf, word_aligned;
  logic [IDX_W-1:0] host_idx;
  logic [31:0]      rbuf_word, status_word, byte_val;

  assign word_aligned = host_addr[1:0] == 2'b00;
  assign host_idx     = host_addr[3:2];
  assign hit_cmd      = host_addr == OFF_CMD;
  assign hit_stat     = host_addr == OFF_STAT;
  assign hit_wbuf     = host_addr[7:4] == PAGE_WBUF;
  assign hit_rbuf     = host_addr[7:4] == PAGE_RBUF;

  mbx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (host_wr_en && hit_cmd),
    .cmd_data  (host_wdata),
    .pend_clr  (host_wr_en && hit_stat && host_wdata[STAT_PEND]),
    .done      (ctl_done),
    .done_err  (ctl_err),
    .done_code (ctl_err_code),
    .busy      (busy),
    .err       (err),
    .err_code  (err_code),
    .pend      (pend),
    .ioc_en    (ioc_en),
    .cmd       (cmd),
    .doorbell  (ctl_doorbell),
    .overrun   (ctl_overrun)
  );

  mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(DATA_W)) u_wbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_wr_en && hit_wbuf && word_aligned),
    .wr_idx  (host_idx),
    .wr_data (host_wdata),
    .rd_idx  (ctl_wbuf_idx),
    .rd_data (ctl_wbuf_word)
  );

  assign ctl_fill_ready = busy;

  mbx_wordbuf #(.WORDS(BUF_WORDS), .DW(DATA_W)) u_rbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_fill_valid && ctl_fill_ready),
    .wr_idx  (ctl_fill_idx),
    .wr_data (ctl_fill_data),
    .rd_idx  (host_idx),
    .rd_data (rbuf_word)
  );

  assign status_word = {err_code, INITIATOR_ID, cmd.sub, 9'd0,
                        pend, err, busy};
  assign byte_val    = {24'd0, 8'(rbuf_word >> {host_addr[1:0], 3'b000})};

  always_comb begin
    host_rdata = '0;
    if (hit_stat)
      host_rdata = status_word;
    else if (hit_rbuf)
      host_rdata = host_byte_rd ? byte_val : rbuf_word;
  end

  assign host_irq   = pend && ioc_en;
  assign ctl_opcode = cmd.op;
  assign ctl_subcmd = cmd.sub;
  assign ctl_size   = cmd.size;
endmodule

// File: rtl/ctl_mailbox_chk.sv
module ctl_mailbox_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       pend,
  input logic       doorbell,
  input logic       done,
  input logic [7:0] opcode,
  input logic       irq,
  input logic       overrun
);
  assert_doorbell_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |=> !doorbell);

  assert_busy_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> doorbell);

  assert_doorbell_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    doorbell |-> busy);

  assert_busy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_cmd_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(opcode));

  assert_irq_needs_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind ctl_mailbox ctl_mailbox_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .pend     (pend),
  .doorbell (ctl_doorbell),
  .done     (ctl_done),
  .opcode   (ctl_opcode),
  .irq      (host_irq),
  .overrun  (ctl_overrun)
);

// File: tb/ctl_mailbox_test.sv
`timescale 1ns/1ps
module ctl_mailbox_test;
  localparam logic [7:0] INIT = 8'h2C;
  localparam logic [31:0] ID_W = {8'd0, INIT, 16'd0};

  typedef enum int {S_RDATA, S_IRQ, S_BELL, S_OVR, S_OP, S_SUB, S_SIZE,
                    S_WBUF, S_READY} sel_t;
  typedef struct {
    sel_t        sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  host_addr = 0;
  logic        host_wr_en = 0, host_byte_rd = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        host_irq, ctl_doorbell, ctl_fill_ready, ctl_overrun;
  logic [7:0]  ctl_opcode, ctl_size;
  logic [3:0]  ctl_subcmd;
  logic [1:0]  ctl_wbuf_idx = 0, ctl_fill_idx = 0;
  logic [31:0] ctl_wbuf_word, ctl_fill_data = 0;
  logic        ctl_fill_valid = 0, ctl_done = 0, ctl_err = 0;
  logic [7:0]  ctl_err_code = 0;

  int checks = 0, errors = 0;
  item_t sb[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  ctl_mailbox #(.INITIATOR_ID(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr_en(host_wr_en),
    .host_wdata(host_wdata), .host_byte_rd(host_byte_rd), .host_rdata(host_rdata),
    .host_irq(host_irq), .ctl_doorbell(ctl_doorbell), .ctl_opcode(ctl_opcode),
    .ctl_subcmd(ctl_subcmd), .ctl_size(ctl_size), .ctl_wbuf_idx(ctl_wbuf_idx),
    .ctl_wbuf_word(ctl_wbuf_word), .ctl_fill_valid(ctl_fill_valid),
    .ctl_fill_ready(ctl_fill_ready), .ctl_fill_idx(ctl_fill_idx),
    .ctl_fill_data(ctl_fill_data), .ctl_done(ctl_done), .ctl_err(ctl_err),
    .ctl_err_code(ctl_err_code), .ctl_overrun(ctl_overrun)
  );

  function automatic logic [31:0] observe(sel_t s);
    case (s)
      S_RDATA: return host_rdata;
      S_IRQ:   return {31'd0, host_irq};
      S_BELL:  return {31'd0, ctl_doorbell};
      S_OVR:   return {31'd0, ctl_overrun};
      S_OP:    return {24'd0, ctl_opcode};
      S_SUB:   return {28'd0, ctl_subcmd};
      S_SIZE:  return {24'd0, ctl_size};
      S_WBUF:  return ctl_wbuf_word;
      default: return {31'd0, ctl_fill_ready};
    endcase
  endfunction

  // monitor: compares queued expectations 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sb.pop_front();
        got = observe(it.sel);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_v(sel_t s, logic [31:0] v, string tag);
    item_t it;
    it.sel = s; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic expect_rd(logic [7:0] a, logic by, logic [31:0] v, string tag);
    host_addr = a;
    host_byte_rd = by;
    expect_v(S_RDATA, v, tag);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic host_write(logic [7:0] a, logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr_en = 1;
    tick();
    host_wr_en = 0;
  endtask

  task automatic finish_cmd(logic e, logic [7:0] code);
    ctl_done = 1; ctl_err = e; ctl_err_code = code;
    tick();
    ctl_done = 0; ctl_err = 0; ctl_err_code = 0;
  endtask

  task automatic fill(logic [1:0] i, logic [31:0] d);
    ctl_fill_valid = 1; ctl_fill_idx = i; ctl_fill_data = d;
    tick();
    ctl_fill_valid = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    expect_rd(8'h04, 0, ID_W, "R1 status after reset");
    expect_v(S_IRQ, 0, "R1 irq after reset");
    expect_v(S_BELL, 0, "R1 doorbell after reset");
    expect_v(S_OVR, 0, "R1 overrun after reset");
    expect_v(S_READY, 0, "R10 fill not ready when idle");
    tick();

    // R2 / R3 / R8 command accept
    host_write(8'h00, 32'h0008_31A5);
    expect_v(S_BELL, 1, "R2 doorbell pulse");
    expect_v(S_OP, 32'hA5, "R2 opcode");
    expect_v(S_SUB, 32'h3, "R2 subcmd");
    expect_v(S_SIZE, 32'h08, "R2 size");
    expect_rd(8'h04, 0, ID_W | 32'h3001, "R3 R8 status busy with sub echo");
    tick();
    expect_v(S_BELL, 0, "R2 doorbell single cycle");

    // R9 write buffer
    host_write(8'h84, 32'hDEAD_BEEF);
    ctl_wbuf_idx = 2'd1;
    expect_v(S_WBUF, 32'hDEAD_BEEF, "R9 controller reads word 1");
    expect_rd(8'h84, 0, 32'h0, "R9 write buffer reads zero");
    tick();
    expect_rd(8'h00, 0, 32'h0, "R9 command reads zero");
    tick();

    // R7 overrun
    host_write(8'h00, 32'h0000_0011);
    expect_v(S_OP, 32'hA5, "R7 opcode held on overrun");
    expect_v(S_OVR, 1, "R7 overrun set");
    expect_v(S_BELL, 0, "R7 no doorbell on overrun");
    tick();

    // R10 fill and reads
    expect_v(S_READY, 1, "R10 ready while busy");
    fill(2'd2, 32'h4433_2211);
    expect_rd(8'h98, 0, 32'h4433_2211, "R10 word read");
    tick();
    expect_rd(8'h9A, 1, 32'h0000_0033, "R10 byte read lane 2");
    tick();
    expect_rd(8'h99, 1, 32'h0000_0022, "R10 byte read lane 1");
    tick();

    // R4 R5 completion with error and ioc
    finish_cmd(1, 8'h5C);
    expect_rd(8'h04, 0, 32'h5C00_0000 | ID_W | 32'h3006, "R4 R5 status after done");
    expect_v(S_IRQ, 1, "R5 irq raised");
    expect_v(S_READY, 0, "R10 ready low after done");
    tick();

    // R10 fill refused while idle
    fill(2'd2, 32'hFFFF_FFFF);
    expect_rd(8'h98, 0, 32'h4433_2211, "R10 idle fill ignored");
    tick();

    // R11 done while idle
    finish_cmd(0, 8'h00);
    expect_rd(8'h04, 0, 32'h5C00_0000 | ID_W | 32'h3006, "R11 idle done ignored");
    tick();

    // R6 clear semantics
    host_write(8'h04, 32'hFFFF_FFFB);
    expect_rd(8'h04, 0, 32'h5C00_0000 | ID_W | 32'h3006, "R6 other bits ignored");
    expect_v(S_IRQ, 1, "R6 irq kept");
    tick();
    host_write(8'h04, 32'h0000_0004);
    expect_rd(8'h04, 0, 32'h5C00_0000 | ID_W | 32'h3002, "R6 pending cleared");
    expect_v(S_IRQ, 0, "R6 irq cleared");
    tick();

    // R4 new command clears error, no ioc
    host_write(8'h00, 32'h0001_2007);
    expect_rd(8'h04, 0, ID_W | 32'h2001, "R4 error cleared on accept");
    expect_v(S_OVR, 1, "R7 overrun sticky");
    tick();
    finish_cmd(0, 8'h00);
    expect_rd(8'h04, 0, ID_W | 32'h2000, "R5 no pending without ioc");
    expect_v(S_IRQ, 0, "R5 irq low without ioc");
    tick();

    // R5 enable follows newest command
    host_write(8'h00, 32'h0000_5109);
    tick();
    finish_cmd(0, 8'h00);
    expect_v(S_IRQ, 1, "R5 irq with ioc");
    tick();
    host_write(8'h00, 32'h0000_600A);
    expect_v(S_IRQ, 0, "R5 irq masked by newest command");
    expect_rd(8'h04, 0, ID_W | 32'h6005, "R5 stale pending kept");
    tick();
    tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule